// File: doc/BRIEF.md
# Pixel Clock Synthesizer Parameter Search

This block turns a requested pixel period, given in picoseconds, into the three settings of a frequency synthesizer: a multiplier `k`, a divider `n` and a post-shift `p2`. The requested period is first limited from below and checked against an upper bound. The post-shift is then chosen from the size of the period, and the shifted period becomes the search target `L`.

For every multiplier from 1 to 31, the block divides `256016 * k` by `L` with a restoring shift-subtract divider that produces one quotient bit per clock. A multiplier becomes the new best candidate when its quotient is usable and its remainder is smaller than every remainder seen so far. When the scan ends, the block raises either a valid flag with the chosen settings or an error flag. The period the settings produce is `(256016 * k / n) >> p2`.

A request is issued with a one-cycle start pulse. The result flags stay where they are until the next request is accepted.

Top module: `pixclk_search`

## Requirements
- R1: After reset, `valid_o` and `err_o` are low and `k_o`, `n_o` and `p2_o` are zero.
- R2: An accepted request whose period exceeds 2048128 (256016 shifted left by 3) sets `err_o` at the next clock edge, with `k_o`, `n_o` and `p2_o` at zero.
- R3: Before any other step, a period below 5000 is replaced by 5000, so such a request returns exactly what a request for 5000 returns.
- R4: `p2_o` is 3 when the clamped period times 16 is less than 256016, and 2 otherwise. The search target `L` is the clamped period shifted left by `p2`.
- R5: For k = 1..31, with n = floor(256016*k / L) and remainder r = 256016*k mod L, a candidate is accepted only when 0 < n < 128 and r is strictly below the best remainder so far. The best remainder starts at `L`. The last accepted candidate is reported, so among equal remainders the lowest k wins.
- R6: If no candidate is accepted, `err_o` is raised instead of `valid_o`, and `k_o`, `n_o` and `p2_o` read zero.
- R7: For a request inside the range, the result flag becomes visible 31 x 23 = 713 clock edges after the edge that accepts the request. The 23 is the bit width of 256016 x 31, and one divider step takes one clock.
- R8: `valid_o` and `err_o` are never high together. Both are low while a search runs. Once set, a flag and the outputs hold until the next request is accepted.
- R9: A start pulse that arrives while a search is running is ignored and does not change the result or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, sampled when idle |
| period_i | input | 24 | Requested pixel period in picoseconds |
| k_o | output | 5 | Chosen multiplier |
| n_o | output | 7 | Chosen divider |
| p2_o | output | 2 | Chosen post-shift |
| valid_o | output | 1 | Result is valid |
| err_o | output | 1 | Request rejected or no candidate found |

## Verification
The bench builds the block with its default parameters: base 256016, a floor of 5000 ps, 31 multipliers, a divider limit of 128 and a 24-bit period. With these values a full search takes about 714 cycles. That is short enough to sweep about a hundred periods, spread geometrically from zero to the 24-bit maximum. The sweep covers both post-shift regions and the clamp region. It also reaches the band just under the range limit, where every quotient is zero and the no-candidate error is raised. Each result is compared with an arithmetic model of the search, along with its latency and how long it holds.

// File: rtl/pixclk_search.sv
module pixclk_search #(
  parameter int BASE       = 256016,
  parameter int MIN_PERIOD = 5000,
  parameter int K_LAST     = 31,
  parameter int N_LIMIT    = 128,
  parameter int PW         = 24,
  localparam int KW        = $clog2(K_LAST + 1),
  localparam int NW        = $clog2(N_LIMIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] period_i,
  output logic [KW-1:0] k_o,
  output logic [NW-1:0] n_o,
  output logic [1:0]    p2_o,
  output logic          valid_o,
  output logic          err_o
);
  localparam int  MW    = $clog2(BASE * K_LAST + 1);
  localparam int  LW    = PW + 3;
  localparam int  CW    = $clog2(MW);
  localparam longint LIMIT = longint'(BASE) * 8;

  logic          run;
  logic [KW-1:0] k_cur, bk;
  logic [NW-1:0] bn;
  logic [CW-1:0] bit_cnt;
  logic [MW-1:0] mq, mk;
  logic [LW:0]   rem;
  logic [LW-1:0] lval, best;
  logic [1:0]    p2r;

  logic [PW-1:0] per_c;
  logic          too_big;
  logic [1:0]    p2_sel;
  logic [LW-1:0] l_sel;

  assign per_c   = (period_i < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : period_i;
  assign too_big = 64'(per_c) > 64'(LIMIT);
  assign p2_sel  = ((64'(per_c) << 4) < 64'(BASE)) ? 2'd3 : 2'd2;
  assign l_sel   = LW'(per_c) << p2_sel;

  logic [LW:0]   rs, r_nx;
  logic          ge, last_bit, take;
  logic [MW-1:0] q_nx;
  logic [KW-1:0] fin_k;
  logic [NW-1:0] fin_n;

  assign rs       = {rem[LW-1:0], mq[MW-1]};
  assign ge       = rs >= {1'b0, lval};
  assign r_nx     = ge ? rs - {1'b0, lval} : rs;
  assign q_nx     = {mq[MW-2:0], ge};
  assign last_bit = bit_cnt == CW'(MW - 1);
  assign take     = (q_nx != '0) && (q_nx < MW'(N_LIMIT)) && (r_nx < {1'b0, best});
  assign fin_k    = take ? k_cur : bk;
  assign fin_n    = take ? NW'(q_nx) : bn;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run <= 1'b0; valid_o <= 1'b0; err_o <= 1'b0;
      k_o <= '0; n_o <= '0; p2_o <= '0;
      k_cur <= '0; bk <= '0; bn <= '0; bit_cnt <= '0;
      mq <= '0; mk <= '0; rem <= '0; lval <= '0; best <= '0; p2r <= '0;
    end else if (!run) begin
      if (start_i) begin
        valid_o <= 1'b0;
        k_o <= '0; n_o <= '0; p2_o <= '0;
        if (too_big) begin
          err_o <= 1'b1;
        end else begin
          err_o   <= 1'b0;
          run     <= 1'b1;
          p2r     <= p2_sel;
          lval    <= l_sel;
          best    <= l_sel;
          mq      <= MW'(BASE);
          mk      <= MW'(BASE);
          rem     <= '0;
          bit_cnt <= '0;
          k_cur   <= KW'(1);
          bk      <= '0;
          bn      <= '0;
        end
      end
    end else begin
      mq      <= q_nx;
      rem     <= r_nx;
      bit_cnt <= bit_cnt + 1'b1;
      if (last_bit) begin
        if (take) begin
          best <= r_nx[LW-1:0];
          bk   <= k_cur;
          bn   <= NW'(q_nx);
        end
        bit_cnt <= '0;
        rem     <= '0;
        mk      <= mk + MW'(BASE);
        mq      <= mk + MW'(BASE);
        k_cur   <= k_cur + 1'b1;
        if (k_cur == KW'(K_LAST)) begin
          run <= 1'b0;
          if (fin_k != '0) begin
            valid_o <= 1'b1;
            k_o     <= fin_k;
            n_o     <= fin_n;
            p2_o    <= p2r;
          end else begin
            err_o <= 1'b1;
          end
        end
      end
    end
  end

  // R2
  range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run && 64'(period_i) > 64'(LIMIT)) |=> (err_o && !valid_o && k_o == '0));

  // R8
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R8
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (!valid_o && !err_o));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (valid_o && $stable(k_o) && $stable(n_o) && $stable(p2_o)));

  // R5
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (k_o != '0 && n_o != '0 && (p2_o == 2'd2 || p2_o == 2'd3)));

  // R6
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (k_o == '0 && n_o == '0 && p2_o == '0));
endmodule

// File: tb/pixclk_search_bench.sv
module pixclk_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint BASE = 256016;
  localparam int LAT = 31 * 23 + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] period = '0;
  logic [4:0] k;
  logic [6:0] n;
  logic [1:0] p2;
  logic valid, err;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixclk_search u_pixclk_search (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_i(period),
    .k_o(k), .n_o(n), .p2_o(p2), .valid_o(valid), .err_o(err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_calc(input longint per, output int ek, output int en,
                          output int ep, output int ev, output int ee);
    longint pc, l, best, m;
    ek = 0; en = 0; ep = 0; ev = 0; ee = 0;
    pc = (per < 5000) ? 5000 : per;
    if (pc > BASE * 8) begin ee = 1; return; end
    ep = ((pc << 4) < BASE) ? 3 : 2;
    l = pc << ep;
    best = l;
    for (int kk = 1; kk <= 31; kk++) begin
      m = BASE * kk;
      if ((m / l) != 0 && (m / l) < 128 && (m % l) < best) begin
        best = m % l; ek = kk; en = int'(m / l);
      end
    end
    if (ek == 0) begin ee = 1; ep = 0; end else ev = 1;
  endtask

  task automatic run_one(input longint per, input string req, input bit late_start);
    int ek, en, ep, ev, ee, cyc;
    ref_calc(per, ek, en, ep, ev, ee);
    period = 24'(per);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!(valid || err) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (late_start && cyc == 50) begin
        period = 24'hFFFFFF;
        start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(valid == ev[0] && err == ee[0], req, {valid, err}, {ev[0], ee[0]});
    chk(k == 5'(ek) && n == 7'(en) && p2 == 2'(ep), req,
        {k, n, p2}, {5'(ek), 7'(en), 2'(ep)});
    chk(cyc == ((ev == 0 && per > BASE * 8) ? 1 : LAT), "R7", cyc,
        (ev == 0 && per > BASE * 8) ? 1 : LAT);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    longint p;
    int ek5, en5, ep5, ev5, ee5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!valid && !err, "R1", {valid, err}, 0);
    chk(k == 0 && n == 0 && p2 == 0, "R1", {k, n, p2}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 range limit
    run_one(2048129, "R2", 1'b0);
    run_one(24'hFFFFFF, "R2", 1'b0);
    run_one(2048128, "R6", 1'b0);
    // R3 clamp
    ref_calc(5000, ek5, en5, ep5, ev5, ee5);
    run_one(0, "R3", 1'b0);
    chk(k == 5'(ek5) && n == 7'(en5), "R3", {k, n}, {5'(ek5), 7'(en5)});
    run_one(4999, "R3", 1'b0);
    run_one(5000, "R3", 1'b0);
    // R4 post-shift boundary
    run_one(16000, "R4", 1'b0);
    run_one(16001, "R4", 1'b0);
    run_one(16002, "R4", 1'b0);
    // R6 no-candidate band
    run_one(1984124, "R6", 1'b0);
    run_one(1984125, "R6", 1'b0);
    // R5 sweep
    p = 5001;
    while (p < 2100000) begin
      run_one(p, "R5", 1'b0);
      p = p + p / 12 + 37;
    end
    // R9 start during search ignored
    run_one(30000, "R9", 1'b1);
    // R8 hold
    repeat (5) @(negedge clk);
    ref_calc(30000, ek5, en5, ep5, ev5, ee5);
    chk(valid && !err && k == 5'(ek5) && n == 7'(en5), "R8", {valid, err, k, n},
        {1'b1, 1'b0, 5'(ek5), 7'(en5)});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule